// File: doc/BRIEF.md
# Byte-Stream Register Command Processor

This block sits between a byte-oriented link receiver/transmitter and a bank of user registers. It parses a stream of incoming octets, each qualified by a one-cycle strobe, into register reads and writes on a simple user-side bus. That bus has a parameterised address, a write-data output, a read-data input and one-cycle read and write strobes. Read results go back as octets through a request/busy transmit handshake.

Two command families share one parser. The first is a readable hexadecimal form suited to typing at a terminal. In this form hex fields fill from the right, and surplus digits fall off the top. Stray characters are skipped, ESC abandons a command, and each read reply is closed by a line feed. The second is a raw binary form with fixed-length fields, meant for programs. Address and data widths are parameters and must be multiples of 8.

Top module: `regcmd_proc`

## Requirements
- R1: While `rst` is high at a rising edge, and in the cycle after it, `reg_rd_stb`, `reg_wr_stb` and `tx_stb` are low.
- R2: A text read starts with the byte 'r' or 'R', then takes hex address digits, then a terminator. Each digit enters the address at the least significant nibble. Digits beyond ADDR_W/4 drop out at the most significant end. The reply is the read data as DATA_W/4 uppercase ASCII hex characters, most significant nibble first with leading zeros kept, followed by one 0x0A.
- R3: In text commands, hex digits are accepted in either case. CR (0x0D) or LF (0x0A) ends a command. Any byte other than a hex digit, comma (0x2C), CR, LF or ESC is ignored. A second terminator after a finished command, such as the LF of CR/LF, has no effect.
- R4: A text write starts with 'w' or 'W', then takes address digits, a comma (0x2C), data digits and a terminator. The comma moves digit entry from the address field to the data field. The command produces one `reg_wr_stb` with that address and data, and no reply bytes.
- R5: ESC (0x1B) at any point in a text command abandons it. No strobe and no reply result.
- R6: The byte 0x00 starts a binary read. Exactly ADDR_W/8 address bytes follow, most significant first. Their values are never treated as control characters, and no terminator is needed. The reply is DATA_W/8 raw bytes, most significant first.
- R7: The byte 0x01 starts a binary write. ADDR_W/8 address bytes follow, then DATA_W/8 data bytes, each field most significant first, with no separator or terminator. The last data byte causes one `reg_wr_stb`.
- R8: `reg_rd_stb` and `reg_wr_stb` last one cycle each and are never high together. `reg_addr` and `reg_wdata` hold the command's values while the strobe is high. `reg_rdata` is sampled in the cycle right after `reg_rd_stb`.
- R9: `tx_stb` is high for one cycle per reply byte. It is never raised in the cycle after a cycle in which `tx_busy` was high. The block waits for `tx_busy` to fall for as long as needed.
- R10: While no command is in progress, a byte that is not 'r', 'R', 'w', 'W', 0x00 or 0x01 is discarded with no effect.
- R11: The address field, and the data field, clear to zero when a command starts. Digits left over from an earlier command never reach a later one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_byte | input | 8 | Received octet |
| rx_stb | input | 1 | One-cycle qualifier for `rx_byte` |
| tx_byte | output | 8 | Reply octet, valid with `tx_stb` |
| tx_stb | output | 1 | One-cycle request to send `tx_byte` |
| tx_busy | input | 1 | Transmitter still sending |
| reg_addr | output | ADDR_W | Register address |
| reg_rdata | input | DATA_W | Read data from the user logic |
| reg_wdata | output | DATA_W | Write data to the user logic |
| reg_rd_stb | output | 1 | One-cycle read request |
| reg_wr_stb | output | 1 | One-cycle write request |

## Verification
The assertions assume that the transmitter raises `tx_busy` no later than the cycle after it sees `tx_stb`. The bench's transmitter model does this one edge after each request, and it can also hold busy high for hundreds of cycles. They also assume that bytes sent while a reply is being produced may be dropped. The bench therefore starts each new command only after the scoreboard has seen every expected strobe and reply byte. Read data is driven valid only in the cycle after `reg_rd_stb`, which exercises the sampling point.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;

  typedef enum logic [2:0] {
    P_IDLE, P_TADDR, P_TDATA, P_BADDR, P_BDATA, P_RWAIT, P_RCAP, P_TX
  } parse_st_t;

  typedef enum logic [1:0] {
    S_IDLE, S_WAIT, S_GAP
  } ser_st_t;

  localparam logic [7:0] C_LF    = 8'h0A;
  localparam logic [7:0] C_CR    = 8'h0D;
  localparam logic [7:0] C_ESC   = 8'h1B;
  localparam logic [7:0] C_COMMA = 8'h2C;
  localparam logic [7:0] C_BRD   = 8'h00;
  localparam logic [7:0] C_BWR   = 8'h01;

  function automatic logic [7:0] nib2asc(input logic [3:0] n);
    if (n < 4'd10) return 8'h30 + {4'h0, n};
    else           return 8'h37 + {4'h0, n};
  endfunction

endpackage

// File: rtl/cmdp_byte_class.sv
module cmdp_byte_class
  import cmdp_pkg::*;
(
  input  logic [7:0] byte_in,
  output logic       is_hex,
  output logic [3:0] nib,
  output logic       is_term,
  output logic       is_comma,
  output logic       is_esc,
  output logic       is_rd,
  output logic       is_wr,
  output logic       is_brd,
  output logic       is_bwr
);
  always_comb begin
    is_hex = 1'b0;
    nib    = 4'h0;
    if (byte_in >= 8'h30 && byte_in <= 8'h39) begin
      is_hex = 1'b1;
      nib    = byte_in[3:0];
    end else if ((byte_in >= 8'h41 && byte_in <= 8'h46) ||
                 (byte_in >= 8'h61 && byte_in <= 8'h66)) begin
      is_hex = 1'b1;
      nib    = byte_in[3:0] + 4'd9;
    end
  end

  assign is_term  = (byte_in == C_LF) || (byte_in == C_CR);
  assign is_comma = (byte_in == C_COMMA);
  assign is_esc   = (byte_in == C_ESC);
  assign is_rd    = (byte_in == 8'h72) || (byte_in == 8'h52);
  assign is_wr    = (byte_in == 8'h77) || (byte_in == 8'h57);
  assign is_brd   = (byte_in == C_BRD);
  assign is_bwr   = (byte_in == C_BWR);
endmodule

// File: rtl/cmdp_field.sv
module cmdp_field #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         sh_nib,
  input  logic         sh_byte,
  input  logic [3:0]   nib,
  input  logic [7:0]   byte_in,
  output logic [W-1:0] q
);
  logic [W-1:0] q_n;

  always_comb begin
    q_n = q;
    if (clr)          q_n = '0;
    else if (sh_byte) q_n = {q[W-9:0], byte_in};
    else if (sh_nib)  q_n = {q[W-5:0], nib};
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_n;
  end
endmodule

// File: rtl/cmdp_tx_ser.sv
module cmdp_tx_ser
  import cmdp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              text,
  input  logic [DATA_W-1:0] load_data,
  input  logic              tx_busy,
  output logic [7:0]        tx_byte,
  output logic              tx_stb,
  output logic              done
);
  localparam int DNIB = DATA_W / 4;
  localparam int CW   = $clog2(DNIB + 1);

  ser_st_t           st, st_n;
  logic [DATA_W-1:0] sbuf, sbuf_n;
  logic [CW-1:0]     left, left_n;
  logic              txt, txt_n, lf, lf_n;
  logic [7:0]        byte_n;
  logic              stb_n;

  assign done = (st == S_WAIT) && !tx_busy && (left == '0) && !lf;

  always_comb begin
    st_n   = st;
    sbuf_n = sbuf;
    left_n = left;
    txt_n  = txt;
    lf_n   = lf;
    byte_n = tx_byte;
    stb_n  = 1'b0;
    case (st)
      S_IDLE: if (load) begin
        sbuf_n = load_data;
        txt_n  = text;
        lf_n   = text;
        left_n = text ? CW'(DNIB) : CW'(DATA_W / 8);
        st_n   = S_WAIT;
      end
      S_WAIT: if (!tx_busy) begin
        if (left != '0) begin
          stb_n  = 1'b1;
          left_n = left - 1'b1;
          st_n   = S_GAP;
          if (txt) begin
            byte_n = nib2asc(sbuf[DATA_W-1 -: 4]);
            sbuf_n = sbuf << 4;
          end else begin
            byte_n = sbuf[DATA_W-1 -: 8];
            sbuf_n = sbuf << 8;
          end
        end else if (lf) begin
          stb_n  = 1'b1;
          byte_n = C_LF;
          lf_n   = 1'b0;
          st_n   = S_GAP;
        end else begin
          st_n = S_IDLE;
        end
      end
      S_GAP:   st_n = S_WAIT;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      sbuf    <= '0;
      left    <= '0;
      txt     <= 1'b0;
      lf      <= 1'b0;
      tx_byte <= 8'h00;
      tx_stb  <= 1'b0;
    end else begin
      st      <= st_n;
      sbuf    <= sbuf_n;
      left    <= left_n;
      txt     <= txt_n;
      lf      <= lf_n;
      tx_byte <= byte_n;
      tx_stb  <= stb_n;
    end
  end
endmodule

// File: rtl/regcmd_proc.sv
module regcmd_proc
  import cmdp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        rx_byte,
  input  logic              rx_stb,
  output logic [7:0]        tx_byte,
  output logic              tx_stb,
  input  logic              tx_busy,
  output logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_rd_stb,
  output logic              reg_wr_stb
);
  localparam int ABYTES = ADDR_W / 8;
  localparam int DBYTES = DATA_W / 8;
  localparam int MAXB   = (ABYTES > DBYTES) ? ABYTES : DBYTES;
  localparam int CW     = $clog2(MAXB + 1);

  logic       c_hex, c_term, c_comma, c_esc, c_rd, c_wr, c_brd, c_bwr;
  logic [3:0] c_nib;

  cmdp_byte_class u_cls (
    .byte_in (rx_byte), .is_hex (c_hex), .nib (c_nib), .is_term (c_term),
    .is_comma(c_comma), .is_esc (c_esc), .is_rd (c_rd), .is_wr (c_wr),
    .is_brd  (c_brd),   .is_bwr (c_bwr)
  );

  parse_st_t     st, st_n;
  logic          is_wr, is_wr_n, is_bin, is_bin_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          a_clr, a_s4, a_s8, d_clr, d_s4, d_s8;
  logic          rd_n, wr_n, ser_load, ser_done;

  cmdp_field #(.W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .clr(a_clr), .sh_nib(a_s4), .sh_byte(a_s8),
    .nib(c_nib), .byte_in(rx_byte), .q(reg_addr)
  );

  cmdp_field #(.W(DATA_W)) u_data (
    .clk(clk), .rst(rst), .clr(d_clr), .sh_nib(d_s4), .sh_byte(d_s8),
    .nib(c_nib), .byte_in(rx_byte), .q(reg_wdata)
  );

  cmdp_tx_ser #(.DATA_W(DATA_W)) u_ser (
    .clk(clk), .rst(rst), .load(ser_load), .text(!is_bin),
    .load_data(reg_rdata), .tx_busy(tx_busy), .tx_byte(tx_byte),
    .tx_stb(tx_stb), .done(ser_done)
  );

  always_comb begin
    st_n     = st;
    is_wr_n  = is_wr;
    is_bin_n = is_bin;
    cnt_n    = cnt;
    a_clr = 1'b0; a_s4 = 1'b0; a_s8 = 1'b0;
    d_clr = 1'b0; d_s4 = 1'b0; d_s8 = 1'b0;
    rd_n = 1'b0; wr_n = 1'b0; ser_load = 1'b0;
    case (st)
      P_IDLE: if (rx_stb) begin
        if (c_rd || c_wr) begin
          a_clr = 1'b1; d_clr = 1'b1;
          is_wr_n = c_wr; is_bin_n = 1'b0;
          st_n = P_TADDR;
        end else if (c_brd || c_bwr) begin
          a_clr = 1'b1; d_clr = 1'b1;
          is_wr_n = c_bwr; is_bin_n = 1'b1;
          cnt_n = '0;
          st_n = P_BADDR;
        end
      end
      P_TADDR: if (rx_stb) begin
        if (c_esc) st_n = P_IDLE;
        else if (c_term) begin
          if (is_wr) begin wr_n = 1'b1; st_n = P_IDLE; end
          else       begin rd_n = 1'b1; st_n = P_RWAIT; end
        end
        else if (c_comma && is_wr) st_n = P_TDATA;
        else if (c_hex) a_s4 = 1'b1;
      end
      P_TDATA: if (rx_stb) begin
        if (c_esc) st_n = P_IDLE;
        else if (c_term) begin wr_n = 1'b1; st_n = P_IDLE; end
        else if (c_hex) d_s4 = 1'b1;
      end
      P_BADDR: if (rx_stb) begin
        a_s8 = 1'b1;
        if (cnt == CW'(ABYTES - 1)) begin
          cnt_n = '0;
          if (is_wr) st_n = P_BDATA;
          else begin rd_n = 1'b1; st_n = P_RWAIT; end
        end else cnt_n = cnt + 1'b1;
      end
      P_BDATA: if (rx_stb) begin
        d_s8 = 1'b1;
        if (cnt == CW'(DBYTES - 1)) begin
          cnt_n = '0; wr_n = 1'b1; st_n = P_IDLE;
        end else cnt_n = cnt + 1'b1;
      end
      P_RWAIT: st_n = P_RCAP;
      P_RCAP: begin ser_load = 1'b1; st_n = P_TX; end
      P_TX:   if (ser_done) st_n = P_IDLE;
      default: st_n = P_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= P_IDLE;
      is_wr      <= 1'b0;
      is_bin     <= 1'b0;
      cnt        <= '0;
      reg_rd_stb <= 1'b0;
      reg_wr_stb <= 1'b0;
    end else begin
      st         <= st_n;
      is_wr      <= is_wr_n;
      is_bin     <= is_bin_n;
      cnt        <= cnt_n;
      reg_rd_stb <= rd_n;
      reg_wr_stb <= wr_n;
    end
  end
endmodule

// File: rtl/regcmd_proc_chk.sv
module regcmd_proc_chk (
  input logic clk,
  input logic rst,
  input logic tx_stb,
  input logic tx_busy,
  input logic reg_rd_stb,
  input logic reg_wr_stb
);
  a_r8_rd_single: assert property (@(posedge clk) disable iff (rst)
    reg_rd_stb |=> !reg_rd_stb);

  a_r8_wr_single: assert property (@(posedge clk) disable iff (rst)
    reg_wr_stb |=> !reg_wr_stb);

  a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(reg_rd_stb && reg_wr_stb));

  a_r9_tx_single: assert property (@(posedge clk) disable iff (rst)
    tx_stb |=> !tx_stb);

  a_r9_no_send_busy: assert property (@(posedge clk) disable iff (rst)
    tx_stb |-> $past(!tx_busy));

  a_r4_no_reply_on_write: assert property (@(posedge clk) disable iff (rst)
    reg_wr_stb |-> !tx_stb);
endmodule

bind regcmd_proc regcmd_proc_chk chk_i (.*);

// File: tb/regcmd_proc_tb_top.sv
module regcmd_proc_tb_top;
  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic [7:0]    rx_byte;
  logic          rx_stb;
  logic [7:0]    tx_byte;
  logic          tx_stb;
  logic          tx_busy;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_rdata;
  logic [DW-1:0] reg_wdata;
  logic          reg_rd_stb;
  logic          reg_wr_stb;

  always #2 clk = ~clk;

  regcmd_proc #(.ADDR_W(AW), .DATA_W(DW)) dut_i (.*);

  int total = 0, bad = 0, extras = 0, tx_seen = 0;
  bit finished = 0;

  logic [15:0] rd_q[$];  string rd_t[$];
  logic [31:0] wr_q[$];  string wr_t[$];
  logic [7:0]  tx_q[$];  string tx_t[$];

  logic rd_win = 1'b0, hold_busy = 1'b0, busy_at_edge = 1'b0;
  int   busy_cnt = 0;

  function automatic logic [15:0] rdv(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5A3C;
  endfunction

  function automatic logic [7:0] hx(input logic [3:0] n);
    return (n < 10) ? 8'h30 + n : 8'h41 + n - 10;
  endfunction

  assign reg_rdata = rd_win ? rdv(reg_addr) : 16'hFFFF;
  assign tx_busy   = hold_busy || (busy_cnt != 0);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // transmitter model and read-data window
  initial forever begin
    @(posedge clk);
    busy_at_edge = tx_busy;
    rd_win <= reg_rd_stb;
    if (tx_stb) busy_cnt <= 3;
    else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
  end

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (!rst) begin
      if (reg_rd_stb) begin
        if (rd_q.size() == 0) begin extras++; check(0, "R8 unexpected read", {16'h0, reg_addr}, 0); end
        else begin
          logic [15:0] e; string t;
          e = rd_q.pop_front(); t = rd_t.pop_front();
          check(reg_addr == e, t, {16'h0, reg_addr}, {16'h0, e});
        end
      end
      if (reg_wr_stb) begin
        if (wr_q.size() == 0) begin extras++; check(0, "R4 unexpected write", {reg_addr, reg_wdata}, 0); end
        else begin
          logic [31:0] e; string t;
          e = wr_q.pop_front(); t = wr_t.pop_front();
          check({reg_addr, reg_wdata} == e, t, {reg_addr, reg_wdata}, e);
        end
      end
      if (tx_stb) begin
        tx_seen++;
        check(!busy_at_edge, "R9 sent while busy", 1, 0);
        if (tx_q.size() == 0) begin extras++; check(0, "R2 unexpected reply", {24'h0, tx_byte}, 0); end
        else begin
          logic [7:0] e; string t;
          e = tx_q.pop_front(); t = tx_t.pop_front();
          check(tx_byte == e, t, {24'h0, tx_byte}, {24'h0, e});
        end
      end
    end
  end

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); rx_byte = b; rx_stb = 1'b1;
    @(negedge clk); rx_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send_byte(s[i]);
  endtask

  task automatic exp_text_read(input logic [15:0] a, input string tag);
    logic [15:0] d;
    d = rdv(a);
    rd_q.push_back(a); rd_t.push_back(tag);
    for (int i = 3; i >= 0; i--) begin tx_q.push_back(hx(d[i*4 +: 4])); tx_t.push_back(tag); end
    tx_q.push_back(8'h0A); tx_t.push_back(tag);
  endtask

  task automatic exp_bin_read(input logic [15:0] a, input string tag);
    logic [15:0] d;
    d = rdv(a);
    rd_q.push_back(a); rd_t.push_back(tag);
    tx_q.push_back(d[15:8]); tx_t.push_back(tag);
    tx_q.push_back(d[7:0]);  tx_t.push_back(tag);
  endtask

  task automatic exp_write(input logic [15:0] a, input logic [15:0] d, input string tag);
    wr_q.push_back({a, d}); wr_t.push_back(tag);
  endtask

  task automatic drain();
    while (rd_q.size() + wr_q.size() + tx_q.size() != 0) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    int x0;
    rst = 1'b1; rx_byte = 8'h00; rx_stb = 1'b0;
    repeat (4) @(negedge clk);
    // R1: outputs idle under reset
    check(!reg_rd_stb && !reg_wr_stb && !tx_stb, "R1 reset outputs", {reg_rd_stb, reg_wr_stb, tx_stb}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!reg_rd_stb && !reg_wr_stb && !tx_stb, "R1 after reset", {reg_rd_stb, reg_wr_stb, tx_stb}, 0);

    // R2 plain text read; R8 data only valid in cycle after strobe
    exp_text_read(16'h1234, "R2 text read 1234");
    send_str("r1234\n"); drain();

    // R3 mixed case, spaces, CR/LF with extra LF ignored
    exp_text_read(16'hABCD, "R3 mixed case read");
    send_str("R ab Cd"); send_byte(8'h0D); send_byte(8'h0A); drain();

    // R2 overflow drops oldest digits
    exp_text_read(16'h3456, "R2 overflow address");
    send_str("r123456\n"); drain();

    // R4 text write, no reply
    exp_write(16'h0012, 16'hBEEF, "R4 text write");
    send_str("W12,beef\n"); drain();

    // R3 junk characters ignored inside a write
    exp_write(16'h0123, 16'h0045, "R3 junk ignored");
    send_str("w 1:2-3 , 4 5"); send_byte(8'h0D); drain();

    // R5 ESC abandons write and read
    x0 = extras;
    send_str("w12,34"); send_byte(8'h1B); send_byte(8'h0A);
    send_str("r9"); send_byte(8'h1B); send_byte(8'h0D);
    repeat (40) @(negedge clk);
    check(extras == x0, "R5 escape no access", extras - x0, 0);

    // R10 idle junk discarded
    x0 = extras;
    send_str("xyz\n5,q"); send_byte(8'h0D); send_byte(8'h1B);
    repeat (40) @(negedge clk);
    check(extras == x0, "R10 idle bytes discarded", extras - x0, 0);
    exp_text_read(16'h0007, "R10 parser still idle");
    send_str("r7\n"); drain();

    // R11 buffers cleared at command start
    exp_write(16'h4567, 16'hDEF0, "R11 long write");
    send_str("w1234567,89abcdef0\n"); drain();
    exp_text_read(16'h0005, "R11 address cleared");
    send_str("r5\n"); drain();
    exp_write(16'h0000, 16'h0007, "R11 data and address cleared");
    send_str("w,7\n"); drain();

    // R6 binary read, control-valued address bytes
    exp_bin_read(16'h1234, "R6 binary read");
    send_byte(8'h00); send_byte(8'h12); send_byte(8'h34); drain();
    exp_bin_read(16'h1B0A, "R6 binary read control bytes");
    send_byte(8'h00); send_byte(8'h1B); send_byte(8'h0A); drain();

    // R7 binary write
    exp_write(16'h0D1B, 16'h0A2C, "R7 binary write");
    send_byte(8'h01); send_byte(8'h0D); send_byte(8'h1B); send_byte(8'h0A); send_byte(8'h2C);
    drain();

    // R9 long busy stall
    hold_busy = 1'b1;
    x0 = tx_seen;
    exp_text_read(16'h0077, "R9 after long busy");
    send_str("r77\n");
    repeat (300) @(negedge clk);
    check(tx_seen == x0, "R9 no send while busy", tx_seen - x0, 0);
    hold_busy = 1'b0;
    drain();

    check(rd_q.size() + wr_q.size() + tx_q.size() == 0, "R2 all expected seen",
          rd_q.size() + wr_q.size() + tx_q.size(), 0);
    summary();
  end
endmodule